// File: doc/BRIEF.md
# Quarter-Tile Half-Precision Outer-Product Accumulator

This block updates a square accumulator tile of half-precision values with four independent outer products, one per quadrant. Each quadrant takes one half of a first-source vector as its column of multiplicands and one half of a second-source vector as its row of multiplicands. Every tile element in the quadrant receives one fused multiply-add: the element's old value plus the product of its two multiplicands, rounded once. An optional subtract mode negates the first multiplicand, which turns the update into old value minus product.

The block contains a 32-entry vector register file, the tile store and a sequencer. The sequencer issues one multiply-add per clock and visits every tile element exactly once. Software-side logic (or a bench) loads vectors and tile elements through simple write ports. It then pulses `start_i` with the register selectors and the mode, waits for `done_o`, and reads the tile back. The first source is an even register among registers 0 to 15, equal to twice `nsel_i`. The second source is register 16 plus twice `msel_i`. Either source can instead be a pair of consecutive registers.

Top module: `qtop_quad_mac`

## Requirements
- R1: After reset `busy_o` and `done_o` are low and every tile element reads 0x0000.
- R2: A `start_i` sampled while idle raises `busy_o` at the next edge. `busy_o` stays high for exactly 64 clock cycles, one tile element per cycle. `done_o` is then high for exactly one cycle while `busy_o` is low.
- R3: With single sources, tile element index r*8+c (r = row 0..7, c = column 0..7) becomes fma(A[r], B[c], old). A is register 2*`nsel_i`, B is register 16+2*`msel_i`, and lane k of a vector occupies bits [16k+15:16k].
- R4: When `npair_i` is 1, the first source for columns 4..7 is register 2*`nsel_i`+1. When `mpair_i` is 1, the second source for rows 4..7 is register 17+2*`msel_i`. Lane numbering is unchanged.
- R5: Each update is a fused multiply-add with a single round-to-nearest-even step. An exact zero from opposite-signed terms gives +0.
- R6: With `sub_i` = 1 the sign of the first multiplicand is inverted before the multiply-add.
- R7: Subnormal inputs are used at full value, and results below the normal range are produced as rounded subnormals.
- R8: Any NaN input, infinity times zero, or a sum of opposite infinities yields 0x7E00. A rounded magnitude beyond 65504 yields a signed infinity (0x7C00/0xFC00).
- R9: While busy, `start_i` and tile writes through `tl_we_i` have no effect. The run completes with the operands and mode latched at its start, and no second run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a run (honoured only when idle) |
| sub_i | input | 1 | Subtract mode: negate first multiplicand |
| nsel_i | input | 3 | First source selector (register 2*nsel_i) |
| msel_i | input | 3 | Second source selector (register 16+2*msel_i) |
| npair_i | input | 1 | First source is a register pair |
| mpair_i | input | 1 | Second source is a register pair |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| vr_we_i | input | 1 | Vector register write enable |
| vr_idx_i | input | 5 | Vector register write index |
| vr_data_i | input | 128 | Vector register write data |
| tl_we_i | input | 1 | Tile element write enable (idle only) |
| tl_idx_i | input | 6 | Tile element index for read and write |
| tl_wdata_i | input | 16 | Tile element write data |
| tl_rdata_o | output | 16 | Tile element read data at tl_idx_i |

## Verification
The hardest situation to reach from the ports is a collision with a run in flight. This is a second start request together with a tile write, arriving while the sequencer is part-way through the tile. The stimulus raises both in the same mid-run cycle, with altered selectors and mode. The write targets the element visited last, so an accepted write would corrupt that element's addend. An accepted start would stretch or repeat the run. Rounding corners such as ties to even at the subnormal boundary, cancellation that exposes the low product bits, and infinity/NaN cases are placed on the tile diagonal with single-register sources, so each is tested in isolation.

// File: rtl/qtop_pkg.sv
package qtop_pkg;
    localparam int ESZ   = 16;
    localparam int EXP_W = 5;
    localparam int MAN_W = 10;
    typedef logic [ESZ-1:0] half_t;
    localparam half_t QNAN    = 16'h7E00;
    localparam half_t INF_MAG = 16'h7C00;
endpackage

// File: rtl/qtop_vrf.sv
module qtop_vrf #(
    parameter int VL   = 128,
    parameter int NREG = 32,
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk_i,
    input  logic          we_i,
    input  logic [RW-1:0] widx_i,
    input  logic [VL-1:0] wdata_i,
    input  logic [RW-1:0] ra_idx_i,
    output logic [VL-1:0] ra_data_o,
    input  logic [RW-1:0] rb_idx_i,
    output logic [VL-1:0] rb_data_o
);
    logic [VL-1:0] regs_q [NREG];

    always_ff @(posedge clk_i) begin
        if (we_i) regs_q[widx_i] <= wdata_i;
    end

    assign ra_data_o = regs_q[ra_idx_i];
    assign rb_data_o = regs_q[rb_idx_i];
endmodule

// File: rtl/qtop_tile.sv
module qtop_tile #(
    parameter int EW    = 16,
    parameter int NELEM = 64,
    localparam int AW   = $clog2(NELEM)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  logic [AW-1:0] widx_i,
    input  logic [EW-1:0] wdata_i,
    input  logic [AW-1:0] ra_idx_i,
    output logic [EW-1:0] ra_data_o,
    input  logic [AW-1:0] rb_idx_i,
    output logic [EW-1:0] rb_data_o
);
    logic [EW-1:0] elem_q [NELEM];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < NELEM; i++) elem_q[i] <= '0;
        end else if (we_i) begin
            elem_q[widx_i] <= wdata_i;
        end
    end

    assign ra_data_o = elem_q[ra_idx_i];
    assign rb_data_o = elem_q[rb_idx_i];
endmodule

// File: rtl/qtop_hfma.sv
// Half-precision fused multiply-add: y = (neg ? -a : a) * b + c, one RNE rounding.
// Both terms are placed exactly on a common fixed-point grid whose LSB is
// 2^-48 (the weight of the smallest product), summed, then rounded once.
module qtop_hfma
    import qtop_pkg::*;
(
    input  half_t a_i,
    input  half_t b_i,
    input  half_t c_i,
    input  logic  neg_i,
    output half_t y_o
);
    localparam int FW = 82;

    logic             sa, sb, sc, sp, sr;
    logic [EXP_W-1:0] ea, eb, ec, xa, xb, xc;
    logic [MAN_W:0]   ma, mb, mc;
    logic             a_nan, b_nan, c_nan, a_inf, b_inf, c_inf, a_zero, b_zero;
    logic             bad_mul, p_inf;
    logic [2*MAN_W+1:0] prod;
    logic [5:0]       shp, shc;
    logic [FW-1:0]    pmag, cmag, sum, shifted, smask;
    logic [6:0]       lead, sh;
    logic signed [7:0] bexp;
    logic [5:0]       eem1;
    logic [11:0]      kept;
    logic             guard, sticky, rnd;
    logic [16:0]      enc;

    always_comb begin
        sa = a_i[15] ^ neg_i;
        sb = b_i[15];
        sc = c_i[15];
        ea = a_i[14:10];
        eb = b_i[14:10];
        ec = c_i[14:10];
        a_nan  = (&ea) && (|a_i[9:0]);
        b_nan  = (&eb) && (|b_i[9:0]);
        c_nan  = (&ec) && (|c_i[9:0]);
        a_inf  = (&ea) && !(|a_i[9:0]);
        b_inf  = (&eb) && !(|b_i[9:0]);
        c_inf  = (&ec) && !(|c_i[9:0]);
        a_zero = (ea == '0) && !(|a_i[9:0]);
        b_zero = (eb == '0) && !(|b_i[9:0]);
        bad_mul = (a_inf && b_zero) || (b_inf && a_zero);
        p_inf   = (a_inf || b_inf) && !bad_mul;
        sp = sa ^ sb;

        // significands with hidden bit; subnormals use exponent 1
        ma = {|ea, a_i[9:0]};
        mb = {|eb, b_i[9:0]};
        mc = {|ec, c_i[9:0]};
        xa = (ea == '0) ? 5'd1 : ea;
        xb = (eb == '0) ? 5'd1 : eb;
        xc = (ec == '0) ? 5'd1 : ec;

        prod = ma * mb;
        shp  = {1'b0, xa} + {1'b0, xb} - 6'd2;
        shc  = {1'b0, xc} + 6'd23;
        pmag = {{(FW-2*MAN_W-2){1'b0}}, prod} << shp;
        cmag = {{(FW-MAN_W-1){1'b0}}, mc} << shc;

        if (sp == sc) begin
            sum = pmag + cmag;
            sr  = sp;
        end else if (pmag >= cmag) begin
            sum = pmag - cmag;
            sr  = sp;
        end else begin
            sum = cmag - pmag;
            sr  = sc;
        end
        if (sum == '0) sr = (sp == sc) ? sp : 1'b0;

        lead = '0;
        for (int i = 0; i < FW; i++) begin
            if (sum[i]) lead = 7'(i);
        end
        bexp = $signed({1'b0, lead}) - 8'sd33;
        if (bexp >= 8'sd1) begin
            sh   = lead - 7'd10;
            eem1 = 6'(bexp - 8'sd1);
        end else begin
            sh   = 7'd24;
            eem1 = '0;
        end
        shifted = sum >> sh;
        kept    = shifted[11:0];
        smask   = ({{(FW-1){1'b0}}, 1'b1} << (sh - 7'd1)) - {{(FW-1){1'b0}}, 1'b1};
        guard   = sum[sh - 7'd1];
        sticky  = |(sum & smask);
        rnd     = guard && (sticky || kept[0]);
        enc     = {1'b0, eem1, 10'b0} + {5'b0, kept} + {16'b0, rnd};

        if (a_nan || b_nan || c_nan || bad_mul || (p_inf && c_inf && (sp != sc))) begin
            y_o = QNAN;
        end else if (p_inf) begin
            y_o = {sp, INF_MAG[14:0]};
        end else if (c_inf) begin
            y_o = {sc, INF_MAG[14:0]};
        end else if (enc >= {1'b0, INF_MAG}) begin
            y_o = {sr, INF_MAG[14:0]};
        end else begin
            y_o = {sr, enc[14:0]};
        end
    end
endmodule

// File: rtl/qtop_quad_mac.sv
module qtop_quad_mac
    import qtop_pkg::*;
#(
    parameter int VL   = 128,
    parameter int NREG = 32,
    localparam int RW    = $clog2(NREG),
    localparam int SW    = RW - 2,
    localparam int DIM   = (VL / 2) / ESZ,
    localparam int DW    = $clog2(DIM),
    localparam int NELEM = 4 * DIM * DIM,
    localparam int CW    = 2 * DW + 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic          sub_i,
    input  logic [SW-1:0] nsel_i,
    input  logic [SW-1:0] msel_i,
    input  logic          npair_i,
    input  logic          mpair_i,
    output logic          busy_o,
    output logic          done_o,
    input  logic          vr_we_i,
    input  logic [RW-1:0] vr_idx_i,
    input  logic [VL-1:0] vr_data_i,
    input  logic          tl_we_i,
    input  logic [CW-1:0] tl_idx_i,
    input  logic [ESZ-1:0] tl_wdata_i,
    output logic [ESZ-1:0] tl_rdata_o
);
    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic          sub;
        logic [SW-1:0] nsel;
        logic [SW-1:0] msel;
        logic          npair;
        logic          mpair;
    } seq_t;

    seq_t st_d, st_q;

    logic          col_half, row_half;
    logic [DW:0]   row_idx, col_idx;
    logic [CW-1:0] elem_idx;
    logic [RW-1:0] a_reg, b_reg;
    logic [VL-1:0] a_vec, b_vec;
    half_t         a_lane, b_lane, acc_old, fma_y;
    logic          tile_we;
    logic [CW-1:0] tile_widx;
    half_t         tile_wdata;

    // quadrant = cnt[CW-1:CW-2]: high bit picks the row half, low bit the column half
    always_comb begin
        row_half = st_q.cnt[CW-1];
        col_half = st_q.cnt[CW-2];
        row_idx  = {row_half, st_q.cnt[2*DW-1:DW]};
        col_idx  = {col_half, st_q.cnt[DW-1:0]};
        elem_idx = {row_idx, col_idx};
        a_reg    = {1'b0, st_q.nsel, st_q.npair & col_half};
        b_reg    = {1'b1, st_q.msel, st_q.mpair & row_half};
        a_lane   = a_vec[int'(row_idx)*ESZ +: ESZ];
        b_lane   = b_vec[int'(col_idx)*ESZ +: ESZ];
    end

    qtop_vrf #(.VL(VL), .NREG(NREG)) vrf_i (
        .clk_i    (clk_i),
        .we_i     (vr_we_i),
        .widx_i   (vr_idx_i),
        .wdata_i  (vr_data_i),
        .ra_idx_i (a_reg),
        .ra_data_o(a_vec),
        .rb_idx_i (b_reg),
        .rb_data_o(b_vec)
    );

    qtop_hfma fma_i (
        .a_i  (a_lane),
        .b_i  (b_lane),
        .c_i  (acc_old),
        .neg_i(st_q.sub),
        .y_o  (fma_y)
    );

    // sequencer owns the write port while busy; external writes only when idle
    always_comb begin
        tile_we    = st_q.busy | tl_we_i;
        tile_widx  = st_q.busy ? elem_idx : tl_idx_i;
        tile_wdata = st_q.busy ? fma_y : tl_wdata_i;
    end

    qtop_tile #(.EW(ESZ), .NELEM(NELEM)) tile_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (tile_we),
        .widx_i   (tile_widx),
        .wdata_i  (tile_wdata),
        .ra_idx_i (elem_idx),
        .ra_data_o(acc_old),
        .rb_idx_i (tl_idx_i),
        .rb_data_o(tl_rdata_o)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CW'(NELEM - 1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end else if (start_i) begin
            st_d.busy  = 1'b1;
            st_d.cnt   = '0;
            st_d.sub   = sub_i;
            st_d.nsel  = nsel_i;
            st_d.msel  = msel_i;
            st_d.npair = npair_i;
            st_d.mpair = mpair_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
endmodule

// File: rtl/qtop_quad_mac_chk.sv
module qtop_quad_mac_chk #(
    parameter int NE = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [15:0] fma_y
);
    int unsigned run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_cnt <= 0;
        else if (busy) run_cnt <= run_cnt + 1;
        else           run_cnt <= 0;
    end

    a_r2_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    a_r2_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_cnt == NE));
    a_r8_nan_default: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (&fma_y[14:10]) && (|fma_y[9:0])) |-> (fma_y == 16'h7E00));
endmodule

bind qtop_quad_mac qtop_quad_mac_chk #(.NE(NELEM)) chk_i (
    .clk  (clk_i),
    .rst_n(rst_ni),
    .start(start_i),
    .busy (busy_o),
    .done (done_o),
    .fma_y(fma_y)
);

// File: tb/qtop_quad_mac_tb_top.sv
module qtop_quad_mac_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, sub = 1'b0, npair = 1'b0, mpair = 1'b0;
    logic [2:0] nsel = '0, msel = '0;
    logic busy, done;
    logic vr_we = 1'b0;
    logic [4:0] vr_idx = '0;
    logic [127:0] vr_data = '0;
    logic tl_we = 1'b0;
    logic [5:0] tl_idx = '0;
    logic [15:0] tl_wdata = '0, tl_rdata;

    int total = 0;
    int bad = 0;

    logic [127:0] bv [32];
    logic [15:0]  bt [NE];
    logic [15:0]  ex [NE];

    always #(CLK_PERIOD/2) clk = ~clk;

    qtop_quad_mac dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sub_i(sub),
        .nsel_i(nsel), .msel_i(msel), .npair_i(npair), .mpair_i(mpair),
        .busy_o(busy), .done_o(done),
        .vr_we_i(vr_we), .vr_idx_i(vr_idx), .vr_data_i(vr_data),
        .tl_we_i(tl_we), .tl_idx_i(tl_idx), .tl_wdata_i(tl_wdata), .tl_rdata_o(tl_rdata)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic real h2r(input logic [15:0] h);
        real v;
        if (h[14:10] == 0) v = real'(h[9:0]) * $pow(2.0, -24);
        else v = real'(1024 + int'(h[9:0])) * $pow(2.0, int'(h[14:10]) - 25);
        return h[15] ? -v : v;
    endfunction

    function automatic logic [15:0] r2h(input real x);
        real ax, q, fr, fl;
        int e;
        longint fi, enc;
        logic s;
        if (x == 0.0) return 16'h0000;
        s = (x < 0.0);
        ax = s ? -x : x;
        e = 15;
        while (e > -14 && ax < $pow(2.0, e)) e--;
        q = ax / $pow(2.0, e - 10);
        fl = $floor(q);
        fi = longint'(fl);
        fr = q - fl;
        if (fr > 0.5 || (fr == 0.5 && fi[0])) fi++;
        enc = longint'(e + 14) * 1024 + fi;
        if (enc >= 31744) enc = 31744;
        return {s, enc[14:0]};
    endfunction

    function automatic logic [15:0] rnd_half(input int lo, input int hi);
        logic [4:0] e;
        e = 5'(lo + int'($urandom % (hi - lo + 1)));
        return {1'($urandom), e, 10'($urandom)};
    endfunction

    task automatic wr_vreg(input int idx, input logic [127:0] d);
        @(negedge clk);
        vr_we = 1'b1; vr_idx = 5'(idx); vr_data = d;
        @(negedge clk);
        vr_we = 1'b0;
        bv[idx] = d;
    endtask

    task automatic wr_tile(input int idx, input logic [15:0] d);
        @(negedge clk);
        tl_we = 1'b1; tl_idx = 6'(idx); tl_wdata = d;
        @(negedge clk);
        tl_we = 1'b0;
        bt[idx] = d;
    endtask

    task automatic rd_tile(input int idx, output logic [15:0] d);
        tl_idx = 6'(idx);
        #1;
        d = tl_rdata;
    endtask

    task automatic load_random();
        for (int r = 0; r < 32; r++) begin
            logic [127:0] v;
            for (int k = 0; k < 8; k++) v[k*16 +: 16] = rnd_half(11, 18);
            wr_vreg(r, v);
        end
        for (int i = 0; i < NE; i++) wr_tile(i, rnd_half(7, 22));
    endtask

    // reference: quadrant q, rows/cols within it, register choice per half
    task automatic model(input int nf, input int mf, input bit np, input bit mp, input bit sb);
        for (int q = 0; q < 4; q++)
            for (int row = 0; row < 4; row++)
                for (int col = 0; col < 4; col++) begin
                    int r, c, ar, br;
                    logic [15:0] a, b;
                    r  = (q / 2) * 4 + row;
                    c  = (q % 2) * 4 + col;
                    ar = 2 * nf + (np ? q % 2 : 0);
                    br = 16 + 2 * mf + (mp ? q / 2 : 0);
                    a  = bv[ar][r*16 +: 16];
                    b  = bv[br][c*16 +: 16];
                    if (sb) a[15] = ~a[15];
                    ex[r*8 + c] = r2h(h2r(a) * h2r(b) + h2r(bt[r*8 + c]));
                end
    endtask

    task automatic run_op(input int nf, input int mf, input bit np, input bit mp,
                          input bit sb, input bit disturb);
        int cyc;
        @(negedge clk);
        nsel = 3'(nf); msel = 3'(mf); npair = np; mpair = mp; sub = sb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2", "busy after start", 32'(busy), 32'd1);
        cyc = 0;
        while (!done && cyc < 200) begin
            if (disturb && cyc == 10) begin
                start = 1'b1; nsel = ~3'(nf); msel = ~3'(mf); sub = ~sb; npair = ~np;
                tl_we = 1'b1; tl_idx = 6'd63; tl_wdata = 16'h5555;
            end else begin
                start = 1'b0; tl_we = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; tl_we = 1'b0;
        chk("R2", "cycles to done", 32'(cyc), 32'd64);
        chk("R2", "idle at done", 32'(busy), 32'd0);
        @(negedge clk);
        chk("R2", "done one cycle", 32'(done), 32'd0);
        if (disturb) begin
            repeat (3) @(negedge clk);
            chk("R9", "no second run", 32'(busy), 32'd0);
        end
    endtask

    task automatic compare_all(input string req);
        for (int i = 0; i < NE; i++) begin
            logic [15:0] d;
            rd_tile(i, d);
            chk(req, $sformatf("tile[%0d]", i), 32'(d), 32'(ex[i]));
            bt[i] = d;
        end
    endtask

    task automatic t_reset();
        chk("R1", "busy", 32'(busy), 32'd0);
        chk("R1", "done", 32'(done), 32'd0);
        for (int i = 0; i < NE; i++) begin
            logic [15:0] d;
            rd_tile(i, d);
            chk("R1", $sformatf("tile[%0d] cleared", i), 32'(d), 32'd0);
        end
    endtask

    task automatic t_single();      // R3, R5: single sources, add
        load_random();
        model(1, 2, 0, 0, 0);
        run_op(1, 2, 0, 0, 0, 0);
        compare_all("R3");
    endtask

    task automatic t_npair();       // R4: first source is a pair
        load_random();
        model(3, 0, 1, 0, 0);
        run_op(3, 0, 1, 0, 0, 0);
        compare_all("R4");
    endtask

    task automatic t_mpair();       // R4: second source is a pair
        load_random();
        model(0, 7, 0, 1, 0);
        run_op(0, 7, 0, 1, 0, 0);
        compare_all("R4");
    endtask

    task automatic t_sub();         // R6: both pairs, subtract
        load_random();
        model(7, 5, 1, 1, 1);
        run_op(7, 5, 1, 1, 1, 0);
        compare_all("R6");
    endtask

    task automatic t_busy_ignore(); // R9: start and tile write while busy
        load_random();
        model(2, 3, 1, 1, 0);
        run_op(2, 3, 1, 1, 0, 1);
        compare_all("R9");
    endtask

    task automatic t_special();     // R5, R7, R8 on the diagonal (registers 0 and 16)
        logic [127:0] va, vb;
        logic [15:0] d;
        va = {16'h3C00, 16'h7D00, 16'h7C00, 16'h3C03, 16'h0003, 16'h0001, 16'h3C00, 16'h7C00};
        vb = {16'h4000, 16'h3C00, 16'h3C00, 16'h3C03, 16'h3800, 16'h3800, 16'h7BFF, 16'h0000};
        wr_vreg(0, va);
        wr_vreg(16, vb);
        for (int i = 0; i < NE; i++) wr_tile(i, 16'h0000);
        wr_tile(9, 16'h7BFF);
        wr_tile(36, 16'hBC00);
        wr_tile(45, 16'hFC00);
        wr_tile(63, 16'hC000);
        run_op(0, 0, 0, 0, 0, 0);
        rd_tile(0, d);  chk("R8", "inf*0 -> default NaN", 32'(d), 32'h7E00);
        rd_tile(9, d);  chk("R8", "overflow -> inf", 32'(d), 32'h7C00);
        rd_tile(18, d); chk("R7", "subnormal tie to even 0", 32'(d), 32'h0000);
        rd_tile(27, d); chk("R7", "subnormal tie up to even", 32'(d), 32'h0002);
        rd_tile(36, d); chk("R5", "single rounding after cancel", 32'(d), 32'h1E02);
        rd_tile(45, d); chk("R8", "inf - inf -> default NaN", 32'(d), 32'h7E00);
        rd_tile(54, d); chk("R8", "NaN input -> default NaN", 32'(d), 32'h7E00);
        rd_tile(63, d); chk("R5", "exact cancel -> +0", 32'(d), 32'h0000);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_npair();
        t_mpair();
        t_sub();
        t_busy_ignore();
        t_special();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule